// File: doc/BRIEF.md
# Fragment Sequence Checker

This block follows the reassembly of fragmented receive messages for a bank of message objects. An upstream parser hands it one accepted frame at a time. Each frame comes with an object index, a flag saying whether the frame is part of a fragmented message, a start-of-message marker, a fragment count and the number of payload bytes it carries. For every object the block keeps an assembling flag, the last fragment count it accepted and a buffer write offset. It also tells the memory side, one cycle later, whether the frame's bytes are to be stored and at which offset inside the object's buffer.

The protocol mode sets how wide the fragment count is: six bits, four bits or a single toggling bit. A fragment whose count is not one more than the previous count is a fragmentation error. The block then drops that frame and abandons the assembly. When a new start-of-message arrives for an object that is still assembling, the object rewinds to the bottom of its buffer without any error. A transmit-underflow pulse from the transmit side shares the error path. Either error source sets a sticky interrupt flag, which software clears by writing one. It also loads an info register with the failing object number and the error type.

Top module: `frag_seq_checker`

## Requirements
- R1: After reset, irq_o is 0, err_obj_o is 0, err_type_o is 0 and acc_valid_o is 0, and no object is assembling a message.
- R2: A fragmented frame (frm_frag_i=1) with frm_som_i=1 is accepted one cycle later with acc_ptr_o=0. The object records its count and sets its write offset to frm_bytes_i.
- R3: A fragmented continuation frame for an assembling object, whose count equals the stored count plus one modulo the active width, is accepted at the stored offset. The offset then advances by frm_bytes_i, modulo 2^PTR_W.
- R4: mode_i selects the count width: 0 = 6 bits (63 is followed by 0), 1 = 4 bits (frm_cnt_i[5:4] ignored, 15 is followed by 0), 2 or 3 = one bit (only frm_cnt_i[0] is compared, and it must toggle).
- R5: A continuation frame with any other count is a fragmentation error. It is not accepted, irq_o is 1 one cycle later, err_obj_o holds the object index and err_type_o is 0. The object stops assembling, and its later continuation frames are dropped without error until a new start-of-message.
- R6: A start-of-message for an object that is already assembling rewinds its offset to 0 and restarts assembly. It raises no error and leaves irq_o and the info register unchanged.
- R7: A frame with frm_frag_i=0 is accepted at offset 0. It never raises an error and leaves the object's count, offset and assembling flag unchanged.
- R8: A pulse on txu_i sets irq_o one cycle later, loads err_obj_o with txu_obj_i and sets err_type_o to 1.
- R9: flag_wr_i=1 with flag_wr_bit_i=1 clears irq_o on the next cycle. With flag_wr_bit_i=0 the write has no effect. irq_o otherwise holds its value.
- R10: If an error occurs in the same cycle as a clearing write, irq_o is 1 afterwards.
- R11: When a fragmentation error and a transmit underflow occur in the same cycle, the info register records the fragmentation error (object index, type 0).
- R12: Each of the NUM_OBJ objects keeps its own count, offset and assembling flag. Frames for one object do not change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Fragment count width select |
| frm_valid_i | input | 1 | A frame is presented this cycle |
| frm_obj_i | input | 5 | Object index of the frame |
| frm_frag_i | input | 1 | Frame belongs to a fragmented message |
| frm_som_i | input | 1 | Frame starts a new message |
| frm_cnt_i | input | 6 | Fragment count field |
| frm_bytes_i | input | 4 | Payload bytes carried by the frame |
| txu_i | input | 1 | Transmit buffer underflow pulse |
| txu_obj_i | input | 5 | Object that underflowed |
| flag_wr_i | input | 1 | Software write to the interrupt flag position |
| flag_wr_bit_i | input | 1 | Value written at the message-error flag position |
| acc_valid_o | output | 1 | Previous cycle's frame is to be stored |
| acc_ptr_o | output | 8 | Buffer offset for the stored frame |
| irq_o | output | 1 | Message error interrupt flag |
| err_obj_o | output | 5 | Object number of the last message error |
| err_type_o | output | 1 | Last error type: 0 fragmentation, 1 transmit underflow |

## Verification
A corrupted per-object count or assembling flag stays hidden until that object's next continuation frame. That frame then shows it one cycle later, either as a spurious error in irq_o and err_obj_o or as a dropped frame on acc_valid_o. A wrong offset shows up only in acc_ptr_o on the next accepted continuation of the same object, so the stimulus runs several fragments per object and interleaves objects. The count wrap points in each mode and the collisions of an error with a clear or with a second error are driven on purpose, because wrong state there changes the ports only in those cycles.

// File: rtl/frag_seq_pkg.sv
package frag_seq_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    MODE_CNT6   = 2'd0,
    MODE_CNT4   = 2'd1,
    MODE_TOGGLE = 2'd2,
    MODE_TOG_B  = 2'd3
  } frag_mode_e;

  localparam logic ERR_FRAG = 1'b0;
  localparam logic ERR_TXUF = 1'b1;

  function automatic logic [CNT_W-1:0] cnt_mask(input frag_mode_e m);
    case (m)
      MODE_CNT6: cnt_mask = 6'h3F;
      MODE_CNT4: cnt_mask = 6'h0F;
      default:   cnt_mask = 6'h01;
    endcase
  endfunction

endpackage

// File: rtl/frag_obj_table.sv
module frag_obj_table
  import frag_seq_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int PTR_W   = 8,
  localparam int OBJ_W  = $clog2(NUM_OBJ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OBJ_W-1:0] rd_idx,
  output logic             rd_asm,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [PTR_W-1:0] rd_ptr,
  input  logic             wr_en,
  input  logic [OBJ_W-1:0] wr_idx,
  input  logic             wr_asm,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [PTR_W-1:0] wr_ptr
);

  logic             asm_q [NUM_OBJ];
  logic [CNT_W-1:0] cnt_q [NUM_OBJ];
  logic [PTR_W-1:0] ptr_q [NUM_OBJ];

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic sel;
    assign sel = wr_en && (wr_idx == OBJ_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        asm_q[g] <= 1'b0;
        cnt_q[g] <= '0;
        ptr_q[g] <= '0;
      end else if (sel) begin
        asm_q[g] <= wr_asm;
        cnt_q[g] <= wr_cnt;
        ptr_q[g] <= wr_ptr;
      end
    end
  end

  assign rd_asm = asm_q[rd_idx];
  assign rd_cnt = cnt_q[rd_idx];
  assign rd_ptr = ptr_q[rd_idx];

endmodule

// File: rtl/frag_seq_eval.sv
module frag_seq_eval
  import frag_seq_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int BYTE_W = 4
) (
  input  frag_mode_e        mode,
  input  logic              frm_valid,
  input  logic              frm_frag,
  input  logic              frm_som,
  input  logic [CNT_W-1:0]  frm_cnt,
  input  logic [BYTE_W-1:0] frm_bytes,
  input  logic              st_asm,
  input  logic [CNT_W-1:0]  st_cnt,
  input  logic [PTR_W-1:0]  st_ptr,
  output logic              upd_en,
  output logic              upd_asm,
  output logic [CNT_W-1:0]  upd_cnt,
  output logic [PTR_W-1:0]  upd_ptr,
  output logic              accept,
  output logic [PTR_W-1:0]  acc_ptr,
  output logic              frag_err
);

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_m;
  logic [CNT_W-1:0] cnt_exp;
  logic [PTR_W-1:0] bytes_x;

  assign mask    = cnt_mask(mode);
  assign cnt_m   = frm_cnt & mask;
  assign cnt_exp = (st_cnt + CNT_W'(1)) & mask;
  assign bytes_x = {{(PTR_W-BYTE_W){1'b0}}, frm_bytes};

  always_comb begin
    upd_en   = 1'b0;
    upd_asm  = st_asm;
    upd_cnt  = st_cnt;
    upd_ptr  = st_ptr;
    accept   = 1'b0;
    acc_ptr  = '0;
    frag_err = 1'b0;
    if (frm_valid && frm_frag) begin
      if (frm_som) begin
        upd_en  = 1'b1;
        upd_asm = 1'b1;
        upd_cnt = cnt_m;
        upd_ptr = bytes_x;
        accept  = 1'b1;
      end else if (st_asm) begin
        upd_en = 1'b1;
        if (cnt_m == cnt_exp) begin
          upd_cnt = cnt_m;
          upd_ptr = st_ptr + bytes_x;
          accept  = 1'b1;
          acc_ptr = st_ptr;
        end else begin
          upd_asm  = 1'b0;
          frag_err = 1'b1;
        end
      end
    end else if (frm_valid) begin
      accept = 1'b1;
    end
  end

endmodule

// File: rtl/frag_err_report.sv
module frag_err_report
  import frag_seq_pkg::*;
#(
  parameter int OBJ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frag_err,
  input  logic [OBJ_W-1:0] frag_obj,
  input  logic             txu,
  input  logic [OBJ_W-1:0] txu_obj,
  input  logic             flag_wr,
  input  logic             flag_wr_bit,
  output logic             irq,
  output logic [OBJ_W-1:0] info_obj,
  output logic             info_type
);

  logic             irq_d;
  logic             info_en;
  logic [OBJ_W-1:0] obj_d;
  logic             type_d;
  logic             clr;

  assign clr     = flag_wr && flag_wr_bit;
  assign info_en = frag_err || txu;

  always_comb begin
    irq_d = irq;
    if (clr)     irq_d = 1'b0;
    if (info_en) irq_d = 1'b1;
    if (frag_err) begin
      obj_d  = frag_obj;
      type_d = ERR_FRAG;
    end else begin
      obj_d  = txu_obj;
      type_d = ERR_TXUF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      info_obj  <= '0;
      info_type <= ERR_FRAG;
    end else begin
      irq <= irq_d;
      if (info_en) begin
        info_obj  <= obj_d;
        info_type <= type_d;
      end
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    info_en |=> irq); // R10
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !info_en && clr |=> !irq); // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !info_en && !clr |=> $stable(irq)); // R9
  AST_TXU_INFO: assert property (@(posedge clk) disable iff (!rst_n)
    txu && !frag_err |=> info_type == ERR_TXUF && info_obj == $past(txu_obj)); // R8
  AST_FRAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    frag_err |=> info_type == ERR_FRAG && info_obj == $past(frag_obj)); // R11

endmodule

// File: rtl/frag_seq_checker.sv
module frag_seq_checker
  import frag_seq_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int PTR_W   = 8,
  parameter int BYTE_W  = 4,
  localparam int OBJ_W  = $clog2(NUM_OBJ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              frm_valid_i,
  input  logic [OBJ_W-1:0]  frm_obj_i,
  input  logic              frm_frag_i,
  input  logic              frm_som_i,
  input  logic [CNT_W-1:0]  frm_cnt_i,
  input  logic [BYTE_W-1:0] frm_bytes_i,
  input  logic              txu_i,
  input  logic [OBJ_W-1:0]  txu_obj_i,
  input  logic              flag_wr_i,
  input  logic              flag_wr_bit_i,
  output logic              acc_valid_o,
  output logic [PTR_W-1:0]  acc_ptr_o,
  output logic              irq_o,
  output logic [OBJ_W-1:0]  err_obj_o,
  output logic              err_type_o
);

  logic rst_meta, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic             st_asm, upd_en, upd_asm, accept, frag_err;
  logic [CNT_W-1:0] st_cnt, upd_cnt;
  logic [PTR_W-1:0] st_ptr, upd_ptr, acc_ptr;

  frag_obj_table #(.NUM_OBJ(NUM_OBJ), .PTR_W(PTR_W)) u_table (
    .clk(clk), .rst_n(rst_n_s),
    .rd_idx(frm_obj_i), .rd_asm(st_asm), .rd_cnt(st_cnt), .rd_ptr(st_ptr),
    .wr_en(upd_en), .wr_idx(frm_obj_i), .wr_asm(upd_asm),
    .wr_cnt(upd_cnt), .wr_ptr(upd_ptr)
  );

  frag_seq_eval #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_eval (
    .mode(frag_mode_e'(mode_i)), .frm_valid(frm_valid_i), .frm_frag(frm_frag_i),
    .frm_som(frm_som_i), .frm_cnt(frm_cnt_i), .frm_bytes(frm_bytes_i),
    .st_asm(st_asm), .st_cnt(st_cnt), .st_ptr(st_ptr),
    .upd_en(upd_en), .upd_asm(upd_asm), .upd_cnt(upd_cnt), .upd_ptr(upd_ptr),
    .accept(accept), .acc_ptr(acc_ptr), .frag_err(frag_err)
  );

  frag_err_report #(.OBJ_W(OBJ_W)) u_report (
    .clk(clk), .rst_n(rst_n_s),
    .frag_err(frag_err), .frag_obj(frm_obj_i),
    .txu(txu_i), .txu_obj(txu_obj_i),
    .flag_wr(flag_wr_i), .flag_wr_bit(flag_wr_bit_i),
    .irq(irq_o), .info_obj(err_obj_o), .info_type(err_type_o)
  );

  logic             acc_valid_d;
  logic [PTR_W-1:0] acc_ptr_d;

  always_comb begin
    acc_valid_d = accept;
    acc_ptr_d   = accept ? acc_ptr : acc_ptr_o;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc_valid_o <= 1'b0;
      acc_ptr_o   <= '0;
    end else begin
      acc_valid_o <= acc_valid_d;
      acc_ptr_o   <= acc_ptr_d;
    end
  end

  AST_SOM_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n_s)
    frm_valid_i && frm_frag_i && frm_som_i |=> acc_valid_o && acc_ptr_o == '0); // R6
  AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    frm_valid_i && !frm_frag_i && !txu_i && !irq_o && !flag_wr_i |=> !irq_o); // R7
  AST_PLAIN_BASE: assert property (@(posedge clk) disable iff (!rst_n_s)
    frm_valid_i && !frm_frag_i |=> acc_valid_o && acc_ptr_o == '0); // R7

endmodule

// File: tb/frag_seq_checker_test.sv
module frag_seq_checker_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       frm_valid_i = 0, frm_frag_i = 0, frm_som_i = 0;
  logic [4:0] frm_obj_i = 0, txu_obj_i = 0, err_obj_o;
  logic [5:0] frm_cnt_i = 0;
  logic [3:0] frm_bytes_i = 0;
  logic       txu_i = 0, flag_wr_i = 0, flag_wr_bit_i = 0;
  logic       acc_valid_o, irq_o, err_type_o;
  logic [7:0] acc_ptr_o;

  always #(CLK_P/2) clk = ~clk;

  frag_seq_checker uut (.*);

  typedef struct {
    bit    av;
    int    ptr;
    bit    irq;
    int    eobj;
    bit    etype;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  bit m_asm [32];
  int m_cnt [32];
  int m_ptr [32];
  bit m_irq = 0;
  int m_eobj = 0;
  bit m_etype = 0;

  task automatic cyc(input bit v, input int obj, input bit frag, input bit som,
                     input int cnt, input int bytes, input bit txu, input int tobj,
                     input bit fw, input bit fb, input string tag);
    exp_t e;
    int mask;
    bit fe;
    @(negedge clk);
    frm_valid_i = v; frm_obj_i = 5'(obj); frm_frag_i = frag; frm_som_i = som;
    frm_cnt_i = 6'(cnt); frm_bytes_i = 4'(bytes);
    txu_i = txu; txu_obj_i = 5'(tobj); flag_wr_i = fw; flag_wr_bit_i = fb;
    mask = (mode_i == 0) ? 63 : (mode_i == 1) ? 15 : 1;
    fe = 0; e.av = 0; e.ptr = 0;
    if (v && frag) begin
      if (som) begin
        e.av = 1; m_asm[obj] = 1; m_cnt[obj] = cnt & mask; m_ptr[obj] = bytes;
      end else if (m_asm[obj]) begin
        if ((cnt & mask) == ((m_cnt[obj] + 1) & mask)) begin
          e.av = 1; e.ptr = m_ptr[obj];
          m_cnt[obj] = cnt & mask; m_ptr[obj] = (m_ptr[obj] + bytes) % 256;
        end else begin
          fe = 1; m_asm[obj] = 0;
        end
      end
    end else if (v) e.av = 1;
    if (fw && fb) m_irq = 0;
    if (fe || txu) m_irq = 1;
    if (fe) begin m_eobj = obj; m_etype = 0; end
    else if (txu) begin m_eobj = tobj; m_etype = 1; end
    e.irq = m_irq; e.eobj = m_eobj; e.etype = m_etype; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    frm_valid_i = 0; txu_i = 0; flag_wr_i = 0; flag_wr_bit_i = 0;
  endtask

  task automatic frm(input int obj, input bit som, input int cnt, input int bytes,
                     input string tag);
    cyc(1, obj, 1, som, cnt, bytes, 0, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (acc_valid_o !== e.av || (e.av && acc_ptr_o !== 8'(e.ptr)) ||
          irq_o !== e.irq || err_obj_o !== 5'(e.eobj) || err_type_o !== e.etype) begin
        fails++;
        $display("FAIL %s: got av=%0b ptr=%0d irq=%0b obj=%0d type=%0b exp av=%0b ptr=%0d irq=%0b obj=%0d type=%0b",
                 e.tag, acc_valid_o, acc_ptr_o, irq_o, err_obj_o, err_type_o,
                 e.av, e.ptr, e.irq, e.eobj, e.etype);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (irq_o !== 0 || err_obj_o !== 0 || err_type_o !== 0 || acc_valid_o !== 0) begin
      fails++;
      $display("FAIL R1: got irq=%0b obj=%0d type=%0b av=%0b exp all 0",
               irq_o, err_obj_o, err_type_o, acc_valid_o);
    end
    frm(4, 0, 1, 8, "R1 idle object drops continuation");
    frm(3, 1, 5, 8, "R2 start at base");
    frm(3, 0, 6, 8, "R3 continuation");
    frm(3, 0, 7, 3, "R3 continuation");
    frm(3, 0, 9, 8, "R5 wrong count");
    frm(3, 0, 10, 8, "R5 abandoned object drops");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R9 write zero ignored");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 write one clears");
    frm(7, 1, 62, 8, "R4 mode0 start");
    frm(7, 0, 63, 8, "R4 mode0");
    frm(7, 0, 0, 5, "R4 mode0 wrap 63 to 0");
    frm(7, 1, 20, 6, "R6 restart mid message");
    frm(7, 0, 21, 2, "R6 resumes from base");
    cyc(1, 7, 0, 0, 0, 8, 0, 0, 0, 0, "R7 plain frame");
    frm(7, 0, 22, 2, "R7 state untouched");
    idle();
    @(negedge clk); mode_i = 2'd1;
    frm(12, 1, 15, 4, "R4 mode1 start");
    frm(12, 0, 6'h30, 4, "R4 mode1 wrap upper bits ignored");
    frm(12, 0, 6'h21, 4, "R4 mode1");
    idle();
    @(negedge clk); mode_i = 2'd2;
    frm(31, 1, 1, 1, "R4 toggle start");
    frm(31, 0, 6'h3E, 1, "R4 toggle");
    frm(31, 0, 0, 1, "R4 toggle repeat is error");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 clear");
    cyc(0, 0, 0, 0, 0, 0, 1, 9, 1, 1, "R8 R10 underflow with clear");
    frm(12, 1, 0, 3, "R11 setup");
    cyc(1, 12, 1, 0, 0, 3, 1, 2, 0, 0, "R11 frag error beats underflow");
    frm(0, 1, 0, 4, "R12 obj0 start");
    frm(1, 1, 1, 7, "R12 obj1 start");
    frm(0, 0, 1, 4, "R12 obj0 continues");
    frm(1, 0, 0, 7, "R12 obj1 continues");
    idle();
    repeat (4) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule